// File: doc/BRIEF.md
# SCSI Bus Parity Control Unit

This unit handles byte-lane parity for a 16-bit SCSI data path, with one parity bit for each 8-bit lane. On the transmit side, data words pass straight through a valid/ready stream and pick up one generated parity bit per lane. A sense control can invert the generated parity so that the bus carries deliberately wrong parity, which lets error recovery be exercised.

On the receive side, a capture strobe latches the incoming word and its lane parity bits. When checking is enabled, each active lane is tested for odd parity, and a sticky error status is recorded. Depending on the operating role, an error then raises one of two requests: an attention request when the unit is an initiator, or a halt request when it is a target. The target halt can be suppressed. A second sticky status records parity errors that a remote target reports while this unit is bus master in a data phase. Each status has its own interrupt enable. The interrupt output is a level, formed as the OR of the enabled statuses.

The transmit stream follows standard valid/ready rules. A word is transferred in a cycle where `tx_out_valid` and `tx_out_ready` are both high. The upstream ready is the downstream ready, unchanged, so back-pressure passes through with no storage and no added cycle. The receive port has no back-pressure: every cycle with `rx_valid` high is captured.

Top module: `scsi_par_ctl`

## Requirements
- R1: With `even_sel` low, each `tx_out_par[i]` makes lane i of `tx_out_data` plus that bit hold an odd number of ones. Lane i is bits [8i+7:8i].
- R2: With `even_sel` high, every `tx_out_par` bit is the inverse of its R1 value, which gives even parity on each lane.
- R3: `tx_out_valid` equals `tx_in_valid`, `tx_in_ready` equals `tx_out_ready`, and `tx_out_data` equals `tx_in_data`, all in the same cycle.
- R4: A clock edge with `rx_valid` high loads `rx_data` into `lat_data` and `rx_par` into `lat_par`, visible after that edge. With `rx_valid` low, both hold their values.
- R5: `live_par` equals `rx_par` in the same cycle, active high.
- R6: A capture with `chk_en` high and an active lane whose 8 data bits plus its parity bit hold an even number of ones sets `par_sts` after that edge. With `chk_en` low, no capture sets `par_sts`.
- R7: With `wide_en` low, only lane 0 is checked, and a bad parity on lane 1 leaves `par_sts` unchanged. With `wide_en` high, both lanes are checked.
- R8: With `targ_mode` low (initiator) and `auto_atn` high, an R6 error sets `atn_req` after the same edge. With `auto_atn` low or `targ_mode` high, `atn_req` is not set.
- R9: With `targ_mode` high, an R6 error sets `halt_req` unless `dis_halt` is high. An initiator never sets `halt_req`.
- R10: `irq` is high exactly when (`par_sts` and `par_ie`) or (`mdp_sts` and `mdp_ie`). A status whose enable is low is still recorded.
- R11: A cycle with `mdp_rpt`, `mst_data_ph` and `mst_par_en` all high sets `mdp_sts` after the edge. With `mst_par_en` low, `mdp_sts` is not set.
- R12: `par_sts`, `atn_req`, `halt_req` and `mdp_sts` are sticky. `par_clr` clears the first three and `mdp_clr` clears `mdp_sts` at the next edge, but a new set in the same cycle as its clear wins.
- R13: While `rst_n` is low, `lat_data`, `lat_par`, all four status/request outputs and `irq` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_in_valid | input | 1 | Upstream transmit word valid |
| tx_in_ready | output | 1 | Upstream ready (passes through from downstream) |
| tx_in_data | input | 16 | Upstream transmit word |
| tx_out_valid | output | 1 | Bus-side transmit word valid |
| tx_out_ready | input | 1 | Bus-side ready |
| tx_out_data | output | 16 | Bus-side transmit word |
| tx_out_par | output | 2 | Generated lane parity, bit i for lane i |
| even_sel | input | 1 | 1 = generate even (wrong) parity |
| rx_valid | input | 1 | Capture strobe for receive word |
| rx_data | input | 16 | Receive word from bus |
| rx_par | input | 2 | Receive lane parity lines |
| chk_en | input | 1 | Receive parity check enable |
| wide_en | input | 1 | 1 = check both lanes, 0 = lane 0 only |
| lat_data | output | 16 | Latched receive word |
| lat_par | output | 2 | Parity latched with lat_data |
| live_par | output | 2 | Current state of the parity lines |
| targ_mode | input | 1 | 1 = target role, 0 = initiator |
| auto_atn | input | 1 | Raise attention on error as initiator |
| dis_halt | input | 1 | Suppress target halt request |
| par_ie | input | 1 | Interrupt enable for par_sts |
| par_clr | input | 1 | Clear strobe for par_sts, atn_req, halt_req |
| mdp_rpt | input | 1 | Remote target signalled a parity error |
| mst_data_ph | input | 1 | Unit is master in a data phase |
| mst_par_en | input | 1 | Enable for master-side error capture |
| mdp_ie | input | 1 | Interrupt enable for mdp_sts |
| mdp_clr | input | 1 | Clear strobe for mdp_sts |
| par_sts | output | 1 | Sticky bus parity error status |
| mdp_sts | output | 1 | Sticky master data parity error status |
| atn_req | output | 1 | Attention request |
| halt_req | output | 1 | Halt request |
| irq | output | 1 | Level interrupt |

## Verification
The embedded assertions check the following on every cycle:
- the receive latch loads on each strobe and holds its value otherwise;
- the sticky statuses persist until they are cleared, and a set arriving together with a clear still wins;
- a halt request rises only in the target role with the halt allowed;
- the interrupt stays low whenever both enables are low.

Other properties depend on specific input values and sequences of role settings, so only the bench scenarios show them:
- the arithmetic of the generated parity under both sense settings;
- whether a particular bad lane counts, depending on the width and check enable;
- the full role matrix for attention and halt;
- the masked-status case, where a status is set but no interrupt follows.

// File: rtl/scsi_par_pkg.sv
package scsi_par_pkg;
  localparam int LANE_W_DEF = 8;
  localparam int LANES_DEF  = 2;

  // odd parity bit for a lane: data plus bit has an odd count of ones
  function automatic logic odd_bit(input logic [LANE_W_DEF-1:0] b);
    return ~(^b);
  endfunction
endpackage

// File: rtl/scsi_par_tx.sv
module scsi_par_tx
  import scsi_par_pkg::*;
#(
  parameter int LANES  = LANES_DEF,
  parameter int LANE_W = LANE_W_DEF
) (
  input  logic [LANES*LANE_W-1:0] word,
  input  logic                    even_sel,
  output logic [LANES-1:0]        par
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign par[g] = (~(^word[g*LANE_W +: LANE_W])) ^ even_sel;
  end
endmodule

// File: rtl/scsi_par_rx.sv
module scsi_par_rx
  import scsi_par_pkg::*;
#(
  parameter int LANES  = LANES_DEF,
  parameter int LANE_W = LANE_W_DEF
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cap,
  input  logic [LANES*LANE_W-1:0] data_in,
  input  logic [LANES-1:0]        par_in,
  input  logic                    chk_en,
  input  logic                    wide_en,
  output logic [LANES*LANE_W-1:0] data_q,
  output logic [LANES-1:0]        par_q,
  output logic                    err_det
);
  logic [LANES-1:0] lane_bad;

  for (genvar g = 0; g < LANES; g++) begin : g_chk
    logic lane_on;
    assign lane_on     = (g == 0) || wide_en;
    assign lane_bad[g] = lane_on && !(^{data_in[g*LANE_W +: LANE_W], par_in[g]});
  end

  assign err_det = cap && chk_en && (|lane_bad);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q <= '0;
      par_q  <= '0;
    end else if (cap) begin
      data_q <= data_in;
      par_q  <= par_in;
    end
  end

  // R4
  latch_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap |=> (data_q == $past(data_in)) && (par_q == $past(par_in)));
  // R4
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(data_q) && $stable(par_q));
endmodule

// File: rtl/scsi_par_err.sv
module scsi_par_err (
  input  logic clk,
  input  logic rst_n,
  input  logic err_det,
  input  logic targ_mode,
  input  logic auto_atn,
  input  logic dis_halt,
  input  logic par_ie,
  input  logic par_clr,
  input  logic mdp_rpt,
  input  logic mst_data_ph,
  input  logic mst_par_en,
  input  logic mdp_ie,
  input  logic mdp_clr,
  output logic par_sts,
  output logic mdp_sts,
  output logic atn_req,
  output logic halt_req,
  output logic irq
);
  logic atn_set, halt_set, mdp_set;

  assign atn_set  = err_det && !targ_mode && auto_atn;
  assign halt_set = err_det && targ_mode && !dis_halt;
  assign mdp_set  = mdp_rpt && mst_data_ph && mst_par_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      par_sts  <= 1'b0;
      mdp_sts  <= 1'b0;
      atn_req  <= 1'b0;
      halt_req <= 1'b0;
    end else begin
      par_sts  <= err_det  | (par_sts  & ~par_clr);
      atn_req  <= atn_set  | (atn_req  & ~par_clr);
      halt_req <= halt_set | (halt_req & ~par_clr);
      mdp_sts  <= mdp_set  | (mdp_sts  & ~mdp_clr);
    end
  end

  assign irq = (par_sts & par_ie) | (mdp_sts & mdp_ie);

  // R12
  par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (par_sts && !par_clr) |=> par_sts);
  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_det && par_clr) |=> par_sts);
  // R12
  mdp_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mdp_sts && !mdp_clr) |=> mdp_sts);
  // R9
  halt_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halt_req) |-> $past(targ_mode && !dis_halt));
  // R8
  atn_role_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(atn_req) |-> $past(!targ_mode && auto_atn));
  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!par_ie && !mdp_ie) |-> !irq);
endmodule

// File: rtl/scsi_par_ctl.sv
module scsi_par_ctl
  import scsi_par_pkg::*;
#(
  parameter int LANES  = LANES_DEF,
  parameter int LANE_W = LANE_W_DEF,
  localparam int W     = LANES * LANE_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_in_valid,
  output logic             tx_in_ready,
  input  logic [W-1:0]     tx_in_data,
  output logic             tx_out_valid,
  input  logic             tx_out_ready,
  output logic [W-1:0]     tx_out_data,
  output logic [LANES-1:0] tx_out_par,
  input  logic             even_sel,
  input  logic             rx_valid,
  input  logic [W-1:0]     rx_data,
  input  logic [LANES-1:0] rx_par,
  input  logic             chk_en,
  input  logic             wide_en,
  output logic [W-1:0]     lat_data,
  output logic [LANES-1:0] lat_par,
  output logic [LANES-1:0] live_par,
  input  logic             targ_mode,
  input  logic             auto_atn,
  input  logic             dis_halt,
  input  logic             par_ie,
  input  logic             par_clr,
  input  logic             mdp_rpt,
  input  logic             mst_data_ph,
  input  logic             mst_par_en,
  input  logic             mdp_ie,
  input  logic             mdp_clr,
  output logic             par_sts,
  output logic             mdp_sts,
  output logic             atn_req,
  output logic             halt_req,
  output logic             irq
);
  logic err_det;

  assign tx_out_valid = tx_in_valid;
  assign tx_in_ready  = tx_out_ready;
  assign tx_out_data  = tx_in_data;
  assign live_par     = rx_par;

  scsi_par_tx #(.LANES(LANES), .LANE_W(LANE_W)) u_tx (
    .word(tx_in_data), .even_sel(even_sel), .par(tx_out_par));

  scsi_par_rx #(.LANES(LANES), .LANE_W(LANE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cap(rx_valid), .data_in(rx_data), .par_in(rx_par),
    .chk_en(chk_en), .wide_en(wide_en), .data_q(lat_data), .par_q(lat_par),
    .err_det(err_det));

  scsi_par_err u_err (
    .clk(clk), .rst_n(rst_n), .err_det(err_det), .targ_mode(targ_mode),
    .auto_atn(auto_atn), .dis_halt(dis_halt), .par_ie(par_ie), .par_clr(par_clr),
    .mdp_rpt(mdp_rpt), .mst_data_ph(mst_data_ph), .mst_par_en(mst_par_en),
    .mdp_ie(mdp_ie), .mdp_clr(mdp_clr), .par_sts(par_sts), .mdp_sts(mdp_sts),
    .atn_req(atn_req), .halt_req(halt_req), .irq(irq));
endmodule

// File: tb/tb_scsi_par_ctl.sv
module tb_scsi_par_ctl;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tx_in_valid = 0, tx_out_ready = 0, even_sel = 0;
  logic [15:0] tx_in_data = '0;
  logic tx_in_ready, tx_out_valid;
  logic [15:0] tx_out_data;
  logic [1:0] tx_out_par;
  logic rx_valid = 0, chk_en = 0, wide_en = 0;
  logic [15:0] rx_data = '0;
  logic [1:0] rx_par = '0;
  logic [15:0] lat_data;
  logic [1:0] lat_par, live_par;
  logic targ_mode = 0, auto_atn = 0, dis_halt = 0, par_ie = 0, par_clr = 0;
  logic mdp_rpt = 0, mst_data_ph = 0, mst_par_en = 0, mdp_ie = 0, mdp_clr = 0;
  logic par_sts, mdp_sts, atn_req, halt_req, irq;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  typedef struct packed {
    logic [15:0] d;
    logic [1:0]  p;
    logic        s, a, h;
  } item_t;
  item_t sb_q[$];
  logic exp_s = 0, exp_a = 0, exp_h = 0;
  logic cap_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  scsi_par_ctl dut (
    .clk(clk), .rst_n(rst_n), .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
    .tx_in_data(tx_in_data), .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready),
    .tx_out_data(tx_out_data), .tx_out_par(tx_out_par), .even_sel(even_sel),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_par(rx_par), .chk_en(chk_en),
    .wide_en(wide_en), .lat_data(lat_data), .lat_par(lat_par), .live_par(live_par),
    .targ_mode(targ_mode), .auto_atn(auto_atn), .dis_halt(dis_halt), .par_ie(par_ie),
    .par_clr(par_clr), .mdp_rpt(mdp_rpt), .mst_data_ph(mst_data_ph),
    .mst_par_en(mst_par_en), .mdp_ie(mdp_ie), .mdp_clr(mdp_clr), .par_sts(par_sts),
    .mdp_sts(mdp_sts), .atn_req(atn_req), .halt_req(halt_req), .irq(irq));

  function automatic logic oddb(input logic [7:0] b);
    return ~(^b);
  endfunction

  function automatic logic [1:0] good_par(input logic [15:0] d);
    return {oddb(d[15:8]), oddb(d[7:0])};
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver: applies one capture, updates the model and pushes the expected result
  task automatic rx_send(input logic [15:0] d, input logic [1:0] p, input logic clr);
    logic bad;
    bad = chk_en && ((^{d[7:0], p[0]}) == 1'b0 || (wide_en && (^{d[15:8], p[1]}) == 1'b0));
    rx_data = d; rx_par = p; rx_valid = 1; par_clr = clr;
    if (clr) begin exp_s = 0; exp_a = 0; exp_h = 0; end
    if (bad) begin
      exp_s = 1;
      if (!targ_mode && auto_atn) exp_a = 1;
      if (targ_mode && !dis_halt) exp_h = 1;
    end
    sb_q.push_back('{d: d, p: p, s: exp_s, a: exp_a, h: exp_h});
    @(negedge clk);
    rx_valid = 0; par_clr = 0;
  endtask

  task automatic clear_par();
    par_clr = 1;
    @(negedge clk);
    par_clr = 0;
    exp_s = 0; exp_a = 0; exp_h = 0;
  endtask

  // monitor: compares each capture against the scoreboard
  always @(posedge clk) cap_seen <= rx_valid && rst_n;

  initial begin
    forever begin
      @(negedge clk);
      if (cap_seen) begin
        if (sb_q.size() == 0) chk(0, "R4 unexpected capture", 1, 0);
        else begin
          item_t it;
          it = sb_q.pop_front();
          chk(lat_data == it.d, "R4 lat_data", lat_data, it.d);
          chk(lat_par == it.p, "R4 lat_par", lat_par, it.p);
          chk(par_sts == it.s, "R6/R7 par_sts", par_sts, it.s);
          chk(atn_req == it.a, "R8 atn_req", atn_req, it.a);
          chk(halt_req == it.h, "R9 halt_req", halt_req, it.h);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] pats [4];
    pats[0] = 16'h0000; pats[1] = 16'hA5C3; pats[2] = 16'hFF01; pats[3] = 16'h7E80;
    repeat (3) @(negedge clk);
    // R13: reset state
    chk(lat_data == 0 && lat_par == 0, "R13 latch", lat_data, 0);
    chk(!par_sts && !mdp_sts && !atn_req && !halt_req && !irq, "R13 status",
        {par_sts, mdp_sts, atn_req, halt_req, irq}, 0);
    rst_n = 1;
    @(negedge clk);

    // R1, R2, R3: transmit stream
    for (int i = 0; i < 4; i++) begin
      for (int e = 0; e < 2; e++) begin
        tx_in_data = pats[i]; even_sel = e[0];
        tx_in_valid = i[0]; tx_out_ready = ~i[0];
        #1;
        if (e == 0) chk(tx_out_par == good_par(pats[i]), "R1 odd tx parity", tx_out_par, good_par(pats[i]));
        else        chk(tx_out_par == ~good_par(pats[i]), "R2 even tx parity", tx_out_par, ~good_par(pats[i]));
        chk(tx_out_data == pats[i] && tx_out_valid == i[0] && tx_in_ready == ~i[0],
            "R3 passthrough", {tx_out_valid, tx_in_ready}, {i[0], ~i[0]});
        @(negedge clk);
      end
    end
    even_sel = 0;

    // R5: live parity
    for (int k = 0; k < 4; k++) begin
      rx_par = k[1:0]; #1;
      chk(live_par == k[1:0], "R5 live_par", live_par, k);
    end
    @(negedge clk);

    // R6: check disabled, bad parity ignored
    chk_en = 0;
    rx_send(16'h1234, ~good_par(16'h1234), 0);
    rx_send(16'h00F0, good_par(16'h00F0), 0);
    // R6/R7: narrow mode, lane 1 bad ignored, lane 0 bad flagged
    chk_en = 1; wide_en = 0;
    rx_send(16'h5A5A, good_par(16'h5A5A) ^ 2'b10, 0);
    rx_send(16'h5A5A, good_par(16'h5A5A), 0);
    rx_send(16'h3C01, good_par(16'h3C01) ^ 2'b01, 0);
    clear_par();
    // R7: wide mode, lane 1 bad flagged
    wide_en = 1;
    rx_send(16'h8001, good_par(16'h8001) ^ 2'b10, 0);
    clear_par();

    // R8: initiator with auto attention
    targ_mode = 0; auto_atn = 1;
    rx_send(16'h4242, ~good_par(16'h4242), 0);
    clear_par();
    auto_atn = 0;
    rx_send(16'h4242, ~good_par(16'h4242), 0);
    clear_par();
    // R9: target halt, then suppressed
    targ_mode = 1; auto_atn = 1;
    rx_send(16'h0F0F, ~good_par(16'h0F0F), 0);
    clear_par();
    dis_halt = 1;
    rx_send(16'h0F0F, ~good_par(16'h0F0F), 0);
    // R12: sticky across good captures, set wins over clear
    rx_send(16'h1111, good_par(16'h1111), 0);
    rx_send(16'h2222, ~good_par(16'h2222), 1);
    rx_send(16'h3333, good_par(16'h3333), 1);
    dis_halt = 0; targ_mode = 0; auto_atn = 0;

    // R10: masked status still recorded, then enable raises irq
    rx_send(16'hBEEF, ~good_par(16'hBEEF), 0);
    chk(par_sts && !irq, "R10 masked", {par_sts, irq}, 2'b10);
    par_ie = 1; #1;
    chk(irq == 1, "R10 irq enabled", irq, 1);
    clear_par();
    chk(!par_sts && !irq, "R12 cleared", {par_sts, irq}, 0);

    // R11: master data parity
    mdp_rpt = 1; mst_data_ph = 1; mst_par_en = 0;
    @(negedge clk);
    chk(!mdp_sts, "R11 disabled", mdp_sts, 0);
    mst_par_en = 1;
    @(negedge clk);
    mdp_rpt = 0;
    chk(mdp_sts && !irq, "R11 set masked", {mdp_sts, irq}, 2'b10);
    mdp_ie = 1; #1;
    chk(irq, "R10 mdp irq", irq, 1);
    // R12: mdp clear with simultaneous set, then plain clear
    mdp_rpt = 1; mdp_clr = 1;
    @(negedge clk);
    chk(mdp_sts, "R12 mdp set wins", mdp_sts, 1);
    mdp_rpt = 0;
    @(negedge clk);
    mdp_clr = 0;
    chk(!mdp_sts && !irq, "R12 mdp cleared", {mdp_sts, irq}, 0);

    repeat (3) @(negedge clk);
    chk(sb_q.size() == 0, "R4 scoreboard drained", sb_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule